// File: doc/BRIEF.md
# Response Delay Scanner

This block runs once when the link to a serial target comes up. It finds how many filler bytes the target needs between a read header and a valid status byte. It asks a separate frame engine to perform single-byte reads of the capability register, at address 0x14. The first read uses a delay of one filler byte. After each read whose status comes back zero, the delay grows by one. The scan stops at the first read that returns a nonzero status, or when the largest delay allowed has been tried.

The result stays on `probe_lat` after the scan ends, so the frame engine can use it for all later traffic. If no read succeeds, the block raises a failure flag and drives a delay of zero. The system should then treat the target as absent. A delay of zero never counts as usable.

The block keeps to one read at a time. It pulses a request for one cycle, then waits for the frame engine to report completion before it decides on the next step.

Top module: `turnaround_scan`

## Requirements
- R1: After reset, `probe_lat` is 1 and `probe_req`, `scan_done` and `scan_fail` are all 0.
- R2: The cycle after `start` is sampled while the block is idle or finished, `probe_req` is 1 and `probe_lat` is 1. Every request carries `probe_addr` = 0x14 and `probe_len` = 1.
- R3: `probe_req` is high for exactly one cycle per read. No further request is made until `frame_done` has been sampled for that read.
- R4: If `frame_done` arrives with `frame_status` = 0 and the delay used is below MAX_LAT-1, the next cycle raises `probe_req` with `probe_lat` one higher.
- R5: If `frame_done` arrives with a nonzero `frame_status`, then from the next cycle `scan_done` = 1 and `scan_fail` = 0, and `probe_lat` holds the delay used by that read.
- R6: If the read at delay MAX_LAT-1 (14 by default) also returns status 0, then from the next cycle `scan_done` = 1, `scan_fail` = 1 and `probe_lat` = 0. In total, MAX_LAT-1 reads are made.
- R7: A `start` pulse while a scan is in progress is ignored. The delay sequence and the final result are unchanged.
- R8: A `frame_done` while no read is outstanding has no effect. It changes none of `probe_lat`, `scan_done`, `scan_fail` or `probe_req`.
- R9: A `start` after a finished scan clears `scan_done` and `scan_fail` and restarts the scan at delay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan |
| probe_req | output | 1 | One-cycle read request to the frame engine |
| probe_addr | output | ADDR_W | Register address of the read (0x14) |
| probe_len | output | LEN_W | Byte count of the read (1) |
| probe_lat | output | LAT_W | Filler-byte count for the current read; the result after the scan |
| frame_done | input | 1 | Frame engine finished the outstanding read |
| frame_status | input | STAT_W | Status byte returned by that read |
| scan_done | output | 1 | Scan finished, held until the next start |
| scan_fail | output | 1 | No read succeeded; the target is treated as absent |

## Verification
The scanner is driven with directed targets that answer at the first delay, at the last allowed delay, and never. These separate an off-by-one in the loop limit from an off-by-one in the reported value. Random scans choose the answering delay and the response wait of the frame engine, which shows that the block waits for completion rather than counting cycles. Stray `start` pulses during a scan and stray completions after the scan ends are injected. They must leave the sequence of delays and the held result untouched, which tells apart correct gating of these inputs from state that reacts to them.

// File: rtl/turnaround_scan.sv
module turnaround_scan #(
  parameter int MAX_LAT = 15,
  parameter int ADDR_W = 8,
  parameter int STAT_W = 8,
  parameter int LEN_W = 12,
  parameter logic [ADDR_W-1:0] PROBE_ADDR = 8'h14,
  localparam int LAT_W = $clog2(MAX_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              probe_req,
  output logic [ADDR_W-1:0] probe_addr,
  output logic [LEN_W-1:0]  probe_len,
  output logic [LAT_W-1:0]  probe_lat,
  input  logic              frame_done,
  input  logic [STAT_W-1:0] frame_status,
  output logic              scan_done,
  output logic              scan_fail
);

  localparam logic [LAT_W-1:0] LAST_LAT = LAT_W'(MAX_LAT - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} state_t;

  state_t           st;
  logic [LAT_W-1:0] lat_q;
  logic             fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lat_q  <= LAT_W'(1);
      fail_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_FIN:
          if (start) begin
            st     <= S_ISSUE;
            lat_q  <= LAT_W'(1);
            fail_q <= 1'b0;
          end
        S_ISSUE: st <= S_WAIT;
        S_WAIT:
          if (frame_done) begin
            if (frame_status != '0) begin
              st <= S_FIN;
            end else if (lat_q < LAST_LAT) begin
              lat_q <= lat_q + LAT_W'(1);
              st    <= S_ISSUE;
            end else begin
              st     <= S_FIN;
              fail_q <= 1'b1;
              lat_q  <= '0;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign probe_req  = (st == S_ISSUE);
  assign probe_addr = PROBE_ADDR;
  assign probe_len  = LEN_W'(1);
  assign probe_lat  = lat_q;
  assign scan_done  = (st == S_FIN);
  assign scan_fail  = fail_q;

  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |=> !probe_req);

  p_req_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!probe_req && !frame_done && !start) |=> !probe_req);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && frame_done && frame_status == '0 && lat_q < LAST_LAT)
      |=> (probe_req && probe_lat == $past(probe_lat) + LAT_W'(1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !start) |=> (scan_done && $stable(probe_lat) && $stable(scan_fail)));

  p_fail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_fail |-> (scan_done && probe_lat == '0));

  p_lat_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_fail |-> (probe_lat >= LAT_W'(1) && probe_lat <= LAST_LAT));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_done && probe_req));

endmodule

// File: tb/turnaround_scan_tb.sv
module turnaround_scan_tb;
  localparam int MAX_LAT = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       probe_req;
  logic [7:0] probe_addr;
  logic [11:0] probe_len;
  logic [3:0] probe_lat;
  logic       frame_done = 1'b0;
  logic [7:0] frame_status = 8'h00;
  logic       scan_done;
  logic       scan_fail;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  turnaround_scan u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .probe_req(probe_req), .probe_addr(probe_addr), .probe_len(probe_len),
    .probe_lat(probe_lat), .frame_done(frame_done), .frame_status(frame_status),
    .scan_done(scan_done), .scan_fail(scan_fail)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input int k);
    return (k == 0) ? 0 : k;
  endfunction

  function automatic int exp_fail(input int k);
    return (k == 0) ? 1 : 0;
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // k: delay at which the target answers, 0 = never
  task automatic run_scan(input int k, input bit stray);
    pulse_start();
    chk("R2/R9 done cleared", scan_done, 0);
    chk("R9 fail cleared", scan_fail, 0);
    for (int p = 1; p < MAX_LAT; p++) begin
      int t = 0;
      int d;
      while (!probe_req && t < 10) begin
        @(negedge clk);
        t++;
      end
      chk("R3/R4 request seen", probe_req, 1);
      chk("R2/R4 probe delay", probe_lat, p);
      chk("R2 address", probe_addr, 8'h14);
      chk("R2 length", probe_len, 1);
      @(negedge clk);
      chk("R3 single-cycle request", probe_req, 0);
      d = stray ? 2 : int'($urandom % 4);
      for (int i = 0; i < d; i++) begin
        if (stray && i == 0) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3 no request before done", probe_req, 0);
        chk("R7 not finished", scan_done, 0);
      end
      frame_done = 1'b1;
      frame_status = (p == k) ? 8'(($urandom % 255) + 1) : 8'h00;
      @(negedge clk);
      frame_done = 1'b0;
      frame_status = 8'($urandom);
      if (p == k) break;
    end
    chk("R5/R6 done", scan_done, 1);
    chk("R5/R6 fail", scan_fail, exp_fail(k));
    chk("R5/R6 latency", probe_lat, exp_lat(k));
    // R8: stray completion after the scan
    frame_done = 1'b1;
    frame_status = 8'h00;
    @(negedge clk);
    frame_done = 1'b0;
    @(negedge clk);
    chk("R8 done kept", scan_done, 1);
    chk("R8 fail kept", scan_fail, exp_fail(k));
    chk("R8 latency kept", probe_lat, exp_lat(k));
    chk("R8 no request", probe_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 latency", probe_lat, 1);
    chk("R1 req", probe_req, 0);
    chk("R1 done", scan_done, 0);
    chk("R1 fail", scan_fail, 0);
    run_scan(1, 1'b0);
    run_scan(14, 1'b0);
    run_scan(0, 1'b0);
    run_scan(7, 1'b1);
    run_scan(0, 1'b1);
    for (int s = 0; s < 10; s++) run_scan(int'($urandom % 15), ($urandom % 3) == 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule